// File: doc/BRIEF.md
# Nibble ALU with Decimal Adjust

This block is the arithmetic and logic unit of a small 4-bit processor core. On each cycle it takes two 4-bit operands and an operation code, and it returns a 4-bit result and a write-back strobe. Both outputs are combinational. It also holds the carry, zero and decimal-mode flags in its own register. The flags are loaded on the clock edge at which `op_valid` is high. Operand fetch, register write-back and instruction sequencing belong to the surrounding core.

When the decimal flag is set, the adds and subtracts are decimal-adjusted, so that two BCD digits combine into a BCD digit with a decimal carry or borrow. The caller can suppress this adjustment for arithmetic on address-register nibbles with `idx_mode`. Compare never adjusts. The compare and bit-test operations only move flags and never request a write-back. Dedicated codes set or clear each flag on its own.

Top module: `nib_alu`

## Requirements
- R1: While `rst_n` is low, and until the first accepted operation after release, the carry, zero and decimal flags all read 0.
- R2: Operation codes on `op_sel` are: 0 add, 1 add+carry, 2 sub, 3 sub+borrow, 4 compare, 5 and, 6 or, 7 xor, 8 bit test, 9 invert, 10 rotate right through carry, 11 increment, 12 decrement, 13 set C, 14 clear C, 15 set Z, 16 clear Z, 17 set D, 18 clear D. Any other code changes no flag and gives no write-back. The flags change only on a clock edge with `op_valid`=1; with `op_valid`=0 they hold.
- R3: In binary mode, add gives (a+b) mod 16 and add+carry gives (a+b+C) mod 16. C is set to the carry out of bit 3.
- R4: In binary mode, sub gives (a-b) mod 16 and sub+borrow gives (a-b-C) mod 16. C is set when the true difference is negative.
- R5: With D=1 and `idx_mode`=0, an add whose binary sum s (including carry-in) exceeds 9 returns (s-10) mod 16 with C=1. Otherwise it returns s with C=0.
- R6: With D=1 and `idx_mode`=0, a subtract whose true difference d is negative returns (d+10) mod 16 with C=1. Otherwise it returns d with C=0.
- R7: With `idx_mode`=1, add, add+carry, sub and sub+borrow behave as in binary mode whatever the value of D.
- R8: Compare never writes back and is never decimal-adjusted. It sets C to (a<b) and Z to (a==b).
- R9: And, or, xor and invert (~a) write back their result and update only Z. C and D are unchanged.
- R10: Bit test sets Z to ((a&b)==0) and leaves C and D unchanged. It never writes back.
- R11: Rotate right returns {C, a[3:1]}, loads C with a[0], leaves Z unchanged and writes back.
- R12: Increment (a+1) and decrement (a-1) are always binary. C is set to the carry or borrow, and Z is updated.
- R13: Each of the six flag codes changes only its own flag and never writes back.
- R14: Z always reflects the final 4-bit result after any decimal adjustment. `res_o` and `wb_en_o` are valid in the same cycle as the inputs, and the new flags appear after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle; enables the flag load |
| op_sel | input | 5 | Operation code (see R2) |
| opnd_a | input | 4 | First operand / destination value |
| opnd_b | input | 4 | Second operand |
| idx_mode | input | 1 | Operands are address-register nibbles; suppresses decimal adjust |
| res_o | output | 4 | Operation result |
| wb_en_o | output | 1 | Result should be written back |
| carry_o | output | 1 | Registered carry/borrow flag |
| zero_o | output | 1 | Registered zero flag |
| dec_o | output | 1 | Registered decimal-mode flag |

## Verification
The result and the write-back strobe are combinational, so they are due in the same cycle as the operands. The flags are due one rising edge later. The bench changes its inputs on a falling edge and samples `res_o` and `wb_en_o` 1 ns later, before any edge. It then waits for the next falling edge, after the loading edge, and compares the three flags against a flag model held in the bench. Exhaustive add and subtract sweeps in both modes use the same two-step timing.

// File: rtl/nib_alu_pkg.sv
package nib_alu_pkg;

  localparam int NIB_W = 4;
  localparam int OP_W  = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 5'd0,
    OP_ADC = 5'd1,
    OP_SUB = 5'd2,
    OP_SBC = 5'd3,
    OP_CMP = 5'd4,
    OP_AND = 5'd5,
    OP_OR  = 5'd6,
    OP_XOR = 5'd7,
    OP_TST = 5'd8,
    OP_NOT = 5'd9,
    OP_RRC = 5'd10,
    OP_INC = 5'd11,
    OP_DEC = 5'd12,
    OP_SCF = 5'd13,
    OP_RCF = 5'd14,
    OP_SZF = 5'd15,
    OP_RZF = 5'd16,
    OP_SDF = 5'd17,
    OP_RDF = 5'd18
  } alu_op_e;

  typedef struct packed {
    logic c;
    logic z;
    logic d;
  } alu_flags_t;

endpackage

// File: rtl/nib_alu_arith.sv
module nib_alu_arith
  import nib_alu_pkg::*;
#(
  parameter int W = NIB_W
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           cin,
  input  logic           dec_mode,
  output logic [W-1:0]   res,
  output logic           cout
);

  localparam logic [W:0]   DEC_TOP = (W+1)'(9);
  localparam logic [W-1:0] DEC_FIX = W'(6);
  localparam logic [W:0]   ONE     = (W+1)'(1);

  logic [W:0] wide;
  logic       use_cin;

  assign use_cin = ((op == OP_ADC) || (op == OP_SBC)) ? cin : 1'b0;

  always_comb begin
    wide = '0;
    res  = '0;
    cout = 1'b0;
    case (op)
      OP_ADD, OP_ADC: begin
        wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, use_cin};
        if (dec_mode && (wide > DEC_TOP)) begin
          res  = wide[W-1:0] + DEC_FIX;
          cout = 1'b1;
        end else begin
          res  = wide[W-1:0];
          cout = wide[W];
        end
      end
      OP_SUB, OP_SBC, OP_CMP: begin
        wide = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, use_cin};
        cout = wide[W];
        if (dec_mode && (op != OP_CMP) && wide[W]) begin
          res = wide[W-1:0] - DEC_FIX;
        end else begin
          res = wide[W-1:0];
        end
      end
      OP_INC: begin
        wide = {1'b0, a} + ONE;
        res  = wide[W-1:0];
        cout = wide[W];
      end
      OP_DEC: begin
        wide = {1'b0, a} - ONE;
        res  = wide[W-1:0];
        cout = wide[W];
      end
      default: begin
        wide = '0;
        res  = '0;
        cout = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/nib_alu_logic.sv
module nib_alu_logic
  import nib_alu_pkg::*;
#(
  parameter int W = NIB_W
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           cin,
  output logic [W-1:0]   res,
  output logic           cout
);

  always_comb begin
    res  = '0;
    cout = cin;
    case (op)
      OP_AND, OP_TST: res = a & b;
      OP_OR:          res = a | b;
      OP_XOR:         res = a ^ b;
      OP_NOT:         res = ~a;
      OP_RRC: begin
        res  = {cin, a[W-1:1]};
        cout = a[0];
      end
      default: begin
        res  = '0;
        cout = cin;
      end
    endcase
  end

endmodule

// File: rtl/nib_alu_flagreg.sv
module nib_alu_flagreg
  import nib_alu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  alu_flags_t flags_d,
  output alu_flags_t flags_q
);

  alu_flags_t flags_nx;

  always_comb begin
    flags_nx = flags_q;
    if (load) begin
      flags_nx = flags_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else begin
      flags_q <= flags_nx;
    end
  end

endmodule

// File: rtl/nib_alu.sv
module nib_alu
  import nib_alu_pkg::*;
#(
  parameter int W = NIB_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  input  logic [4:0]   op_sel,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic         idx_mode,
  output logic [W-1:0] res_o,
  output logic         wb_en_o,
  output logic         carry_o,
  output logic         zero_o,
  output logic         dec_o
);

  alu_op_e    op;
  alu_flags_t flags_q;
  alu_flags_t flags_d;
  logic [W-1:0] ar_res;
  logic [W-1:0] lg_res;
  logic         ar_c;
  logic         lg_c;
  logic         is_arith;
  logic         is_logic;
  logic         wb_kind;
  logic [W-1:0] sel_res;
  logic         res_zero;
  logic         dec_mode;

  assign op       = alu_op_e'(op_sel);
  assign dec_mode = flags_q.d & ~idx_mode;

  nib_alu_arith #(.W(W)) u_arith (
    .op       (op),
    .a        (opnd_a),
    .b        (opnd_b),
    .cin      (flags_q.c),
    .dec_mode (dec_mode),
    .res      (ar_res),
    .cout     (ar_c)
  );

  nib_alu_logic #(.W(W)) u_logic (
    .op   (op),
    .a    (opnd_a),
    .b    (opnd_b),
    .cin  (flags_q.c),
    .res  (lg_res),
    .cout (lg_c)
  );

  // operation class decode
  always_comb begin
    is_arith = 1'b0;
    is_logic = 1'b0;
    wb_kind  = 1'b0;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_INC, OP_DEC: begin
        is_arith = 1'b1;
        wb_kind  = 1'b1;
      end
      OP_CMP: is_arith = 1'b1;
      OP_AND, OP_OR, OP_XOR, OP_NOT, OP_RRC: begin
        is_logic = 1'b1;
        wb_kind  = 1'b1;
      end
      OP_TST: is_logic = 1'b1;
      default: begin
        is_arith = 1'b0;
        is_logic = 1'b0;
        wb_kind  = 1'b0;
      end
    endcase
  end

  always_comb begin
    sel_res = '0;
    if (is_arith) begin
      sel_res = ar_res;
    end else if (is_logic) begin
      sel_res = lg_res;
    end
  end

  assign res_zero = (sel_res == '0);

  // next flag values
  always_comb begin
    flags_d = flags_q;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_INC, OP_DEC: begin
        flags_d.c = ar_c;
        flags_d.z = res_zero;
      end
      OP_AND, OP_OR, OP_XOR, OP_TST, OP_NOT: flags_d.z = res_zero;
      OP_RRC: flags_d.c = lg_c;
      OP_SCF: flags_d.c = 1'b1;
      OP_RCF: flags_d.c = 1'b0;
      OP_SZF: flags_d.z = 1'b1;
      OP_RZF: flags_d.z = 1'b0;
      OP_SDF: flags_d.d = 1'b1;
      OP_RDF: flags_d.d = 1'b0;
      default: flags_d = flags_q;
    endcase
  end

  nib_alu_flagreg u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (op_valid),
    .flags_d (flags_d),
    .flags_q (flags_q)
  );

  assign res_o   = sel_res;
  assign wb_en_o = op_valid & wb_kind;
  assign carry_o = flags_q.c;
  assign zero_o  = flags_q.z;
  assign dec_o   = flags_q.d;

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(carry_o) && $stable(zero_o) && $stable(dec_o)));

  // R11
  rrc_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == 5'd10) |=> (carry_o == $past(opnd_a[0]) && zero_o == $past(zero_o)));

  // R9
  logic_keeps_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_sel == 5'd5 || op_sel == 5'd6 || op_sel == 5'd7 || op_sel == 5'd9))
      |=> (carry_o == $past(carry_o) && dec_o == $past(dec_o)));

  // R8
  cmp_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == 5'd4) |=> (zero_o == ($past(opnd_a) == $past(opnd_b))
                                      && carry_o == ($past(opnd_a) < $past(opnd_b))));

  // R5
  dec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && dec_o && !idx_mode && op_sel == 5'd0 && opnd_a <= W'(9) && opnd_b <= W'(9))
      |-> (res_o <= W'(9)));

  // R10
  test_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_sel == 5'd8 || op_sel == 5'd4)) |-> !wb_en_o);

endmodule

// File: tb/nib_alu_tb.sv
`timescale 1ns/1ps
module nib_alu_tb;

  logic       clk;
  logic       rst_n;
  logic       op_valid;
  logic [4:0] op_sel;
  logic [3:0] opnd_a;
  logic [3:0] opnd_b;
  logic       idx_mode;
  logic [3:0] res_o;
  logic       wb_en_o;
  logic       carry_o;
  logic       zero_o;
  logic       dec_o;

  int checks = 0;
  int errors = 0;
  bit m_c, m_z, m_d;
  bit finished = 0;

  nib_alu u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .idx_mode(idx_mode),
    .res_o(res_o), .wb_en_o(wb_en_o), .carry_o(carry_o),
    .zero_o(zero_o), .dec_o(dec_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // reference model built from the requirement text
  task automatic model(input int op, input int a, input int b, input bit idx,
                       output int r, output bit wb);
    bit dm;
    int s;
    dm = m_d && !idx;
    r  = 0;
    wb = 0;
    case (op)
      0, 1: begin
        s = a + b + ((op == 1) ? int'(m_c) : 0);
        if (dm) begin
          if (s > 9) begin r = (s - 10) & 15; m_c = 1; end
          else begin r = s; m_c = 0; end
        end else begin r = s & 15; m_c = (s > 15); end
        m_z = (r == 0); wb = 1;
      end
      2, 3: begin
        s = a - b - ((op == 3) ? int'(m_c) : 0);
        if (dm && s < 0) r = (s + 10) & 15;
        else r = s & 15;
        m_c = (s < 0); m_z = (r == 0); wb = 1;
      end
      4: begin m_c = (a < b); m_z = (a == b); end
      5: begin r = a & b; m_z = (r == 0); wb = 1; end
      6: begin r = a | b; m_z = (r == 0); wb = 1; end
      7: begin r = a ^ b; m_z = (r == 0); wb = 1; end
      8: m_z = ((a & b) == 0);
      9: begin r = (~a) & 15; m_z = (r == 0); wb = 1; end
      10: begin r = (int'(m_c) << 3) | (a >> 1); m_c = a[0]; wb = 1; end
      11: begin r = (a + 1) & 15; m_c = (a == 15); m_z = (r == 0); wb = 1; end
      12: begin r = (a - 1) & 15; m_c = (a == 0); m_z = (r == 0); wb = 1; end
      13: m_c = 1;
      14: m_c = 0;
      15: m_z = 1;
      16: m_z = 0;
      17: m_d = 1;
      18: m_d = 0;
      default: ;
    endcase
  endtask

  task automatic run_op(string req, int op, int a, int b, bit idx);
    int r;
    bit wb;
    @(negedge clk);
    op_valid = 1'b1;
    op_sel   = 5'(op);
    opnd_a   = 4'(a);
    opnd_b   = 4'(b);
    idx_mode = idx;
    model(op, a, b, idx, r, wb);
    #1;
    chk(req, "wb_en", int'(wb_en_o), int'(wb));
    if (wb) chk(req, "result", int'(res_o), r);
    @(negedge clk);
    op_valid = 1'b0;
    chk(req, "carry", int'(carry_o), int'(m_c));
    chk(req, "zero", int'(zero_o), int'(m_z));
    chk(req, "decimal", int'(dec_o), int'(m_d));
  endtask

  task automatic t_reset();
    chk("R1", "carry", int'(carry_o), 0);
    chk("R1", "zero", int'(zero_o), 0);
    chk("R1", "decimal", int'(dec_o), 0);
  endtask

  task automatic t_binary_add();
    run_op("R3", 0, 3, 4, 0);
    run_op("R3", 0, 15, 1, 0);
    run_op("R3", 1, 7, 8, 0);
    run_op("R3", 0, 9, 8, 0);
  endtask

  task automatic t_binary_sub();
    run_op("R4", 2, 3, 5, 0);
    run_op("R4", 3, 9, 4, 0);
    run_op("R4", 2, 6, 6, 0);
  endtask

  task automatic t_decimal();
    run_op("R13", 17, 0, 0, 0);
    run_op("R5", 0, 9, 8, 0);
    run_op("R5", 0, 5, 4, 0);
    run_op("R5", 1, 9, 9, 0);
    run_op("R14", 0, 5, 5, 0);
    run_op("R6", 2, 3, 5, 0);
    run_op("R6", 3, 8, 2, 0);
    run_op("R6", 2, 0, 9, 0);
  endtask

  task automatic t_index();
    run_op("R7", 0, 9, 8, 1);
    run_op("R7", 2, 3, 5, 1);
    run_op("R12", 11, 9, 0, 0);
    run_op("R12", 12, 0, 0, 0);
  endtask

  task automatic t_compare();
    run_op("R8", 4, 3, 5, 0);
    run_op("R8", 4, 5, 5, 0);
    run_op("R8", 4, 9, 2, 0);
  endtask

  task automatic t_logic();
    run_op("R13", 13, 0, 0, 0);
    run_op("R9", 5, 12, 3, 0);
    run_op("R9", 6, 12, 3, 0);
    run_op("R9", 7, 10, 10, 0);
    run_op("R9", 9, 15, 0, 0);
    run_op("R10", 8, 6, 8, 0);
    run_op("R10", 8, 6, 2, 0);
  endtask

  task automatic t_rotate();
    run_op("R11", 10, 5, 0, 0);
    run_op("R11", 10, 4, 0, 0);
    run_op("R11", 10, 8, 0, 0);
  endtask

  task automatic t_flag_ops();
    for (int f = 13; f <= 18; f++) run_op("R13", f, 0, 0, 0);
    run_op("R13", 15, 0, 0, 0);
    run_op("R13", 13, 0, 0, 0);
  endtask

  task automatic t_idle();
    @(negedge clk);
    op_valid = 1'b0;
    op_sel   = 5'd14;
    opnd_a   = 4'd0;
    repeat (3) @(negedge clk);
    chk("R2", "carry idle", int'(carry_o), int'(m_c));
    chk("R2", "zero idle", int'(zero_o), int'(m_z));
    run_op("R2", 25, 7, 7, 0);
    run_op("R2", 31, 0, 0, 0);
  endtask

  task automatic t_sweep(bit dmode);
    run_op("R13", dmode ? 17 : 18, 0, 0, 0);
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        run_op(dmode ? "R5" : "R3", 0, a, b, 0);
        run_op(dmode ? "R6" : "R4", 3, a, b, 0);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    op_valid = 1'b0;
    op_sel = 5'd0;
    opnd_a = 4'd0;
    opnd_b = 4'd0;
    idx_mode = 1'b0;
    m_c = 0; m_z = 0; m_d = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_binary_add();
    t_binary_sub();
    t_decimal();
    t_index();
    t_compare();
    t_logic();
    t_rotate();
    t_flag_ops();
    t_idle();
    t_sweep(1'b0);
    t_sweep(1'b1);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule